// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a free-running safety timer that a system must service regularly. A slow tick enable from the system drives a power-of-two prescaler. The prescaler steps a 12-bit down-counter, and when the counter runs out the block raises a one-cycle reset request. Software reaches the block through a small register window on a single-cycle bus. Writes take effect at the clock edge, and reads are combinational from the address.

All control goes through 16-bit magic values written to one key register. One value starts the timer. Another refreshes it. A third opens the prescaler and reload registers for writing, and any other key value closes them again. Once started, the timer cannot be stopped. New divider or reload settings do not take effect at once. They reach the counter a fixed number of slow ticks after the write, and a status flag for each setting stays up until the new value is in use.

Top module: `key_wdog`

## Requirements
- R1: After reset the timer is stopped and the configuration is locked. The divider code reads 0, the reload reads 0xFFF, the status reads 0, and the reset request is low.
- R2: Register offsets are key 0x00, divider code 0x04 (bits 3:0), reload 0x08 (bits 11:0) and status 0x0C (bit 0 = divider update pending, bit 1 = reload update pending). The key register and every other offset read as 0.
- R3: Key 0x5555 unlocks the divider and reload registers, and any other key value locks them. Writes to either register while locked change neither its read-back value nor the status flags.
- R4: Key 0xCCCC starts the timer. While stopped, the block never raises a reset request, whatever the ticks, and key 0xAAAA does not start it.
- R5: Divider code c divides slow ticks by 4·2^c. The largest code is 6 (divide by 256), or 8 (divide by 1024) when PRESC_EXT=1. Larger written codes are stored as the largest code.
- R6: The reload value is 12 bits wide. Written values below 2 are stored as 2.
- R7: After a start or refresh key write, the reset request rises on the (R+1)·D-th slow tick that follows, where R is the active reload value and D is the divide ratio. Clock cycles without slowTick do not count.
- R8: The reset request lasts one clock cycle. The counter then reloads and keeps running, so the next request comes another (R+1)·D ticks later.
- R9: Once running, no key write stops the timer. Keys other than start and refresh do not disturb the count in progress.
- R10: An accepted divider or reload write sets its status flag. The flag clears on the UPDATE_TICKS-th (default 3) slow tick after the write and stays set while no ticks arrive. The counter keeps using the old value until the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| slowTick | input | 1 | One-cycle enable marking a slow-clock tick |
| busAddr | input | 5 | Byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, combinational |
| wdogRstReq | output | 1 | One-cycle reset request on counter expiry |

## Verification
The counter, divider phase and running state are internal, so their faults show up only in when wdogRstReq fires. A wrong divide ratio, an off-by-one reload or a lost tick moves the first request away from the (R+1)·D-th tick. The bench therefore measures that tick index over a sweep of divider codes and reload values, to the exact cycle. A stuck lock or a wrong update delay shows within a few cycles, in the read-back value or in the status bits read after each tick. A timer that stops, or that never starts, shows within one timeout period.

// File: rtl/key_wdog_pkg.sv
package key_wdog_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_KEY    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PRESC  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h0C;

  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;   // restart count from active reload
    logic running;   // timer started
    logic unlocked;  // config registers writable
    logic prescWr;   // accepted divider write
    logic reloadWr;  // accepted reload write
  } ctl_stb_t;
endpackage

// File: rtl/key_wdog_upd.sv
// Shadow register with delayed transfer to the active copy.
module key_wdog_upd #(
  parameter int W = 12,
  parameter int TICKS = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slowTick,
  input  logic         wrStb,
  input  logic [W-1:0] wrVal,
  output logic [W-1:0] shadowVal,
  output logic [W-1:0] activeVal,
  output logic         pending
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadowVal <= RST_VAL;
      activeVal <= RST_VAL;
      waitCnt   <= '0;
    end else if (wrStb) begin
      shadowVal <= wrVal;
      waitCnt   <= CNT_LOAD;
    end else if (slowTick && waitCnt != '0) begin
      waitCnt <= waitCnt - CNT_ONE;
      if (waitCnt == CNT_ONE) activeVal <= shadowVal;
    end
  end

  assign pending = (waitCnt != '0);
endmodule

// File: rtl/key_wdog_ctl.sv
// Key decode, lock and run state.
module key_wdog_ctl
  import key_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctl_stb_t          stb
);
  logic keyWr;
  logic unlockedQ;
  logic runningQ;

  assign keyWr = busWrEn && (busAddr == OFS_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlockedQ <= 1'b0;
      runningQ  <= 1'b0;
    end else begin
      if (keyWr) unlockedQ <= (busWrData == KEY_UNLOCK);
      if (keyWr && busWrData == KEY_START) runningQ <= 1'b1;
    end
  end

  always_comb begin
    stb.loadCnt  = keyWr && (busWrData == KEY_REFRESH || busWrData == KEY_START);
    stb.running  = runningQ;
    stb.unlocked = unlockedQ;
    stb.prescWr  = busWrEn && unlockedQ && (busAddr == OFS_PRESC);
    stb.reloadWr = busWrEn && unlockedQ && (busAddr == OFS_RELOAD);
  end
endmodule

// File: rtl/key_wdog_dp.sv
// Config registers, prescaler, down-counter and read mux.
module key_wdog_dp
  import key_wdog_pkg::*;
#(
  parameter int RELOAD_W = 12,
  parameter int PRESC_EXT = 0,
  parameter int UPDATE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowTick,
  input  ctl_stb_t          stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              wdogRstReq,
  output logic              pendPresc,
  output logic              pendReload
);
  localparam int PCODE_MAX = (PRESC_EXT != 0) ? 8 : 6;
  localparam int PCODE_W = $clog2(PCODE_MAX + 1);
  localparam int FIELD_W = 4;
  localparam int DIV_W = PCODE_MAX + 2;
  localparam logic [FIELD_W-1:0] PCODE_MAX_F = FIELD_W'(PCODE_MAX);
  localparam logic [PCODE_W-1:0] PCODE_MAX_C = PCODE_W'(PCODE_MAX);
  localparam logic [RELOAD_W-1:0] RELOAD_MIN = RELOAD_W'(2);
  localparam logic [RELOAD_W-1:0] RELOAD_RST = '1;

  // write data conditioning
  logic [FIELD_W-1:0]  prescField;
  logic [PCODE_W-1:0]  prescIn;
  logic [RELOAD_W-1:0] reloadField;
  logic [RELOAD_W-1:0] reloadIn;
  logic                unusedBits;

  assign prescField  = busWrData[FIELD_W-1:0];
  assign prescIn     = (prescField > PCODE_MAX_F) ? PCODE_MAX_C : prescField[PCODE_W-1:0];
  assign reloadField = busWrData[RELOAD_W-1:0];
  assign reloadIn    = (reloadField < RELOAD_MIN) ? RELOAD_MIN : reloadField;
  assign unusedBits  = ^busWrData[DATA_W-1:RELOAD_W];

  logic [PCODE_W-1:0]  prescShadow, prescAct;
  logic [RELOAD_W-1:0] reloadShadow, reloadAct;

  key_wdog_upd #(.W(PCODE_W), .TICKS(UPDATE_TICKS), .RST_VAL('0)) u_updPresc (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick),
    .wrStb(stb.prescWr), .wrVal(prescIn),
    .shadowVal(prescShadow), .activeVal(prescAct), .pending(pendPresc)
  );

  key_wdog_upd #(.W(RELOAD_W), .TICKS(UPDATE_TICKS), .RST_VAL(RELOAD_RST)) u_updReload (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick),
    .wrStb(stb.reloadWr), .wrVal(reloadIn),
    .shadowVal(reloadShadow), .activeVal(reloadAct), .pending(pendReload)
  );

  // prescaler: terminal when the low (code+2) bits are all ones
  logic [PCODE_W:0]    shAmt;
  logic [DIV_W-1:0]    divMask;
  logic [DIV_W-1:0]    preDiv;
  logic                stepHit;
  logic [RELOAD_W-1:0] downCnt;
  logic                cntStep;

  assign shAmt   = {1'b0, prescAct} + (PCODE_W + 1)'(2);
  assign divMask = ~({DIV_W{1'b1}} << shAmt);
  assign stepHit = ((preDiv & divMask) == divMask);
  assign cntStep = stb.running && slowTick && !stb.loadCnt && stepHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preDiv     <= '0;
      downCnt    <= RELOAD_RST;
      wdogRstReq <= 1'b0;
    end else begin
      wdogRstReq <= cntStep && (downCnt == '0);
      if (stb.loadCnt) begin
        preDiv  <= '0;
        downCnt <= reloadAct;
      end else if (stb.running && slowTick) begin
        if (stepHit) begin
          preDiv  <= '0;
          downCnt <= (downCnt == '0) ? reloadAct : downCnt - RELOAD_W'(1);
        end else begin
          preDiv <= preDiv + DIV_W'(1);
        end
      end
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_PRESC:  busRdData = DATA_W'(prescShadow);
      OFS_RELOAD: busRdData = DATA_W'(reloadShadow);
      OFS_STATUS: busRdData = DATA_W'({pendReload, pendPresc});
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/key_wdog.sv
module key_wdog
  import key_wdog_pkg::*;
#(
  parameter int RELOAD_W = 12,
  parameter int PRESC_EXT = 0,
  parameter int UPDATE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              wdogRstReq
);
  ctl_stb_t ctlStb;
  logic     pendPresc;
  logic     pendReload;
  logic     runFlag;
  logic     unlockFlag;

  assign runFlag    = ctlStb.running;
  assign unlockFlag = ctlStb.unlocked;

  key_wdog_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .stb(ctlStb)
  );

  key_wdog_dp #(
    .RELOAD_W(RELOAD_W), .PRESC_EXT(PRESC_EXT), .UPDATE_TICKS(UPDATE_TICKS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .stb(ctlStb),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .wdogRstReq(wdogRstReq), .pendPresc(pendPresc), .pendReload(pendReload)
  );
endmodule

// File: rtl/key_wdog_chk.sv
module key_wdog_chk
  import key_wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slowTick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              wdogRstReq,
  input logic              running,
  input logic              unlocked,
  input logic              pendPresc,
  input logic              pendReload
);
  p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdogRstReq |=> !wdogRstReq);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wdogRstReq);

  p_no_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  p_locked_presc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && busWrEn && busAddr == OFS_PRESC && !pendPresc) |=> !pendPresc);

  p_locked_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && busWrEn && busAddr == OFS_RELOAD && !pendReload) |=> !pendReload);

  p_flag_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pendPresc) |-> $past(slowTick));

  p_expiry_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdogRstReq) |-> $past(slowTick));
endmodule

bind key_wdog key_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .busAddr(busAddr),
  .busWrEn(busWrEn), .wdogRstReq(wdogRstReq), .running(runFlag),
  .unlocked(unlockFlag), .pendPresc(pendPresc), .pendReload(pendReload)
);

// File: tb/key_wdog_tb.sv
module key_wdog_tb;
  localparam logic [4:0] A_KEY = 5'h00, A_PRE = 5'h04, A_REL = 5'h08, A_STS = 5'h0C, A_WIN = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slowTick = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        wdogRstReq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  key_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .wdogRstReq(wdogRstReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    busAddr = a;
    #1;
    d = int'(busRdData);
  endtask

  task automatic waitIdle();
    slowTick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      int s;
      rd(A_STS, s);
      if (s == 0) break;
      @(posedge clk); @(negedge clk);
    end
    slowTick = 1'b0;
  endtask

  task automatic configure(input int code, input int rel);
    wr(A_KEY, 16'h5555);
    wr(A_PRE, 16'(code));
    wr(A_REL, 16'(rel));
    waitIdle();
    wr(A_KEY, 16'h0000);
  endtask

  // counts edges after the current one until the first request
  task automatic measure(input int gap, output int m);
    m = 0;
    for (int i = 1; i <= 6000; i++) begin
      slowTick = (i % gap == 0);
      @(posedge clk); @(negedge clk);
      if (wdogRstReq) begin m = i; break; end
    end
    slowTick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int m;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset state and map
    chk("R1 request low", int'(wdogRstReq), 0);
    rd(A_PRE, v); chk("R1 divider code", v, 0);
    rd(A_REL, v); chk("R1 reload", v, 32'hFFF);
    rd(A_STS, v); chk("R1 status", v, 0);
    rd(A_KEY, v); chk("R2 key reads zero", v, 0);
    rd(A_WIN, v); chk("R2 unmapped reads zero", v, 0);

    // R3 lock behaviour
    wr(A_PRE, 16'd3);
    rd(A_PRE, v); chk("R3 locked divider write", v, 0);
    wr(A_REL, 16'd9);
    rd(A_REL, v); chk("R3 locked reload write", v, 32'hFFF);
    rd(A_STS, v); chk("R3 no flag when locked", v, 0);
    wr(A_KEY, 16'h5555);
    wr(A_KEY, 16'h1234);
    wr(A_PRE, 16'd3);
    rd(A_PRE, v); chk("R3 relocked by other key", v, 0);
    wr(A_KEY, 16'h5555);
    wr(A_PRE, 16'd3);
    rd(A_PRE, v); chk("R3 unlocked divider write", v, 3);

    // R10 flag timing: held without ticks, clears on third tick
    rd(A_STS, v); chk("R10 divider flag set", v, 1);
    repeat (5) @(negedge clk);
    rd(A_STS, v); chk("R10 flag held without ticks", v, 1);
    for (int i = 1; i <= 3; i++) begin
      slowTick = 1'b1;
      @(posedge clk); @(negedge clk);
      slowTick = 1'b0;
      rd(A_STS, v); chk("R10 flag after tick", v, (i < 3) ? 1 : 0);
    end
    wr(A_REL, 16'h0010);
    rd(A_STS, v); chk("R10 reload flag set", v, 2);
    waitIdle();

    // R5 / R6 saturation
    wr(A_PRE, 16'd9);
    rd(A_PRE, v); chk("R5 code saturates", v, 6);
    wr(A_REL, 16'd1);
    rd(A_REL, v); chk("R6 reload floor", v, 2);
    wr(A_REL, 16'hFFFF);
    rd(A_REL, v); chk("R6 reload width", v, 32'hFFF);
    waitIdle();
    wr(A_KEY, 16'h0000);

    // R4 stopped timer stays quiet
    configure(0, 2);
    wr(A_KEY, 16'hAAAA);
    seen = 0;
    slowTick = 1'b1;
    repeat (100) begin
      @(posedge clk); @(negedge clk);
      if (wdogRstReq) seen = 1;
    end
    slowTick = 1'b0;
    chk("R4 no request before start", seen, 0);

    // R7 / R8 start, period, repeat
    wr(A_KEY, 16'hCCCC);
    measure(1, m); chk("R7 first period after start", m, 12);
    measure(1, m); chk("R8 second period one-cycle pulse", m, 12);

    // R6 reload floor in timing
    configure(0, 0);
    wr(A_KEY, 16'hAAAA);
    measure(1, m); chk("R6 floored reload period", m, 12);

    // R10 old reload used until the update lands
    wr(A_KEY, 16'h5555);
    wr(A_REL, 16'd5);
    wr(A_KEY, 16'h0000);
    wr(A_KEY, 16'hAAAA);
    measure(1, m); chk("R10 old reload still active", m, 12);
    measure(1, m); chk("R10 new reload applied", m, 24);

    // R7 / R5 sweep over codes and reloads
    for (int c = 0; c <= 6; c++) begin
      for (int k = 0; k < 3; k++) begin
        int rel;
        rel = (k == 0) ? 2 : ((k == 1) ? 3 : 7);
        configure(c, rel);
        wr(A_KEY, 16'hAAAA);
        measure(1, m);
        chk($sformatf("R7 R5 code=%0d reload=%0d", c, rel), m, (rel + 1) * (4 << c));
      end
    end

    // R7 sparse ticks
    configure(1, 2);
    wr(A_KEY, 16'hAAAA);
    measure(3, m); chk("R7 ticks every third cycle", m, 72);

    // R9 key writes do not stop or disturb
    wr(A_KEY, 16'hAAAA);
    slowTick = 1'b1;
    wr(A_KEY, 16'h0000);
    wr(A_KEY, 16'h5555);
    wr(A_KEY, 16'h7777);
    wr(A_KEY, 16'h0000);
    measure(1, m); chk("R9 other keys keep count", m, 20);
    measure(1, m); chk("R9 still running", m, 24);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule